// File: doc/BRIEF.md
# Six-Operation Main Control Decoder

This block turns the operation field and the function field of a 32-bit instruction word into the control points of a single-cycle datapath. The operation field is 6 bits and the function field is 6 bits. The control points are the register-file write enable, the destination specifier choice, the ALU second-operand source, the immediate extender mode, a 2-bit ALU operation, the data-memory write enable, the write-back source and the branch request. The decoder has no clock and no state. Its outputs follow its inputs within the same cycle, so the datapath can apply them in the same cycle in which the instruction word is fetched.

Six operations are recognised: register add, register subtract, OR with an immediate, load word, store word and branch-if-equal. Every other field combination gives an all-zero control word. That word writes nothing, does not branch and makes no other choice that has an effect.

Output encodings: `alu_op_o` is 00 add, 01 subtract, 10 OR. `dst_is_rd_o` set selects the rd specifier and clear selects rt. `b_is_imm_o` set selects the extended immediate. `ext_signed_o` set selects sign extension. `load_sel_o` set selects memory read data for write-back.

Top module: `ctl_decoder`

## Requirements
- R1: Register add is operation 0x00 with function 0x21. It gives reg_we=1, dst_is_rd=1, b_is_imm=0, ext_signed=0, alu_op=00, mem_we=0, load_sel=0 and branch=0.
- R2: Register subtract is operation 0x00 with function 0x23. It gives the same controls as R1 except alu_op=01.
- R3: OR-immediate is operation 0x0D, with any function field. It gives reg_we=1, dst_is_rd=0, b_is_imm=1, ext_signed=0 (zero extension), alu_op=10, mem_we=0, load_sel=0 and branch=0.
- R4: Load word is operation 0x23, with any function field. It gives reg_we=1, dst_is_rd=0, b_is_imm=1, ext_signed=1, alu_op=00, mem_we=0, load_sel=1 and branch=0.
- R5: Store word is operation 0x2B, with any function field. It gives reg_we=0, dst_is_rd=0, b_is_imm=1, ext_signed=1, alu_op=00, mem_we=1, load_sel=0 and branch=0.
- R6: Branch-if-equal is operation 0x04, with any function field. It gives reg_we=0, dst_is_rd=0, b_is_imm=0, ext_signed=1, alu_op=01, mem_we=0, load_sel=0 and branch=1. The subtract lets the datapath use the ALU zero result as the equality test.
- R7: Any operation value other than 0x00, 0x0D, 0x23, 0x2B and 0x04 drives every output to 0.
- R8: Operation 0x00 with a function value other than 0x21 and 0x23 drives every output to 0.
- R9: For a non-zero operation value, the function field has no effect on any output.
- R10: At most one of reg_we, mem_we and branch is 1 at any time. load_sel=1 occurs only together with reg_we=1 and b_is_imm=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation field of the instruction word |
| fn_i | input | 6 | Function field of the instruction word |
| reg_we_o | output | 1 | Register file write enable |
| dst_is_rd_o | output | 1 | 1: write the rd specifier; 0: write the rt specifier |
| b_is_imm_o | output | 1 | 1: ALU second operand is the extended immediate |
| ext_signed_o | output | 1 | 1: sign-extend the immediate; 0: zero-extend it |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 OR |
| mem_we_o | output | 1 | Data memory write enable |
| load_sel_o | output | 1 | 1: write back memory read data; 0: write back the ALU result |
| branch_o | output | 1 | Branch request, qualified by the ALU zero flag in the datapath |

## Verification
Each of the six operations is applied once with its nominal fields. This tells apart the two register operations, which differ only in the ALU code. It also tells apart the two immediate-ALU operations, which differ in extender mode and ALU code. All 64 operation values are then swept with a fixed function field, so every unassigned operation is shown to give the all-zero control word. The 64 function values are swept under operation 0x00, which shows that only 0x21 and 0x23 are accepted. The same function sweep under each of the four non-zero operations shows that the function field is ignored there.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 2;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_ORIMM = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BREQ  = 6'h04;

  localparam logic [FN_W-1:0] FNC_ADD = 6'h21;
  localparam logic [FN_W-1:0] FNC_SUB = 6'h23;

  localparam logic [ALU_W-1:0] ALU_ADD = 2'b00;
  localparam logic [ALU_W-1:0] ALU_SUB = 2'b01;
  localparam logic [ALU_W-1:0] ALU_OR  = 2'b10;

  typedef enum logic [2:0] {
    OPK_NONE,
    OPK_ADD,
    OPK_SUB,
    OPK_ORIMM,
    OPK_LOAD,
    OPK_STORE,
    OPK_BREQ
  } opkind_e;

  typedef struct packed {
    logic             reg_we;
    logic             dst_is_rd;
    logic             b_is_imm;
    logic             ext_signed;
    logic [ALU_W-1:0] alu_op;
    logic             mem_we;
    logic             load_sel;
    logic             branch;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/ctl_op_classify.sv
module ctl_op_classify
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            is_reg_o,
  output opkind_e         kind_o
);

  always_comb begin
    is_reg_o = 1'b0;
    kind_o   = OPK_NONE;
    case (op_i)
      OPC_REG:   is_reg_o = 1'b1;
      OPC_ORIMM: kind_o   = OPK_ORIMM;
      OPC_LOAD:  kind_o   = OPK_LOAD;
      OPC_STORE: kind_o   = OPK_STORE;
      OPC_BREQ:  kind_o   = OPK_BREQ;
      default:   kind_o   = OPK_NONE;
    endcase
  end

  always_comb begin
    if (is_reg_o)
      AST_REG_HAS_NO_KIND: assert (kind_o == OPK_NONE); // R7
  end

endmodule

// File: rtl/ctl_fn_decode.sv
module ctl_fn_decode
  import ctl_pkg::*;
(
  input  logic            en_i,
  input  logic [FN_W-1:0] fn_i,
  output opkind_e         kind_o
);

  always_comb begin
    kind_o = OPK_NONE;
    if (en_i) begin
      case (fn_i)
        FNC_ADD: kind_o = OPK_ADD;
        FNC_SUB: kind_o = OPK_SUB;
        default: kind_o = OPK_NONE;
      endcase
    end
  end

  always_comb begin
    if (!en_i)
      AST_FN_GATED: assert (kind_o == OPK_NONE); // R9
  end

endmodule

// File: rtl/ctl_point_gen.sv
module ctl_point_gen
  import ctl_pkg::*;
(
  input  opkind_e kind_i,
  output ctl_t    ctl_o
);

  always_comb begin
    ctl_o = CTL_IDLE;
    case (kind_i)
      OPK_ADD: begin
        ctl_o.reg_we    = 1'b1;
        ctl_o.dst_is_rd = 1'b1;
        ctl_o.alu_op    = ALU_ADD;
      end
      OPK_SUB: begin
        ctl_o.reg_we    = 1'b1;
        ctl_o.dst_is_rd = 1'b1;
        ctl_o.alu_op    = ALU_SUB;
      end
      OPK_ORIMM: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.b_is_imm = 1'b1;
        ctl_o.alu_op   = ALU_OR;
      end
      OPK_LOAD: begin
        ctl_o.reg_we     = 1'b1;
        ctl_o.b_is_imm   = 1'b1;
        ctl_o.ext_signed = 1'b1;
        ctl_o.alu_op     = ALU_ADD;
        ctl_o.load_sel   = 1'b1;
      end
      OPK_STORE: begin
        ctl_o.mem_we     = 1'b1;
        ctl_o.b_is_imm   = 1'b1;
        ctl_o.ext_signed = 1'b1;
        ctl_o.alu_op     = ALU_ADD;
      end
      OPK_BREQ: begin
        ctl_o.branch     = 1'b1;
        ctl_o.ext_signed = 1'b1;
        ctl_o.alu_op     = ALU_SUB;
      end
      default: ctl_o = CTL_IDLE;
    endcase
  end

  always_comb begin
    AST_ONE_SIDE_EFFECT: assert ($countones({ctl_o.reg_we, ctl_o.mem_we, ctl_o.branch}) <= 1); // R10
    if (ctl_o.load_sel)
      AST_LOAD_NEEDS_WRITE: assert (ctl_o.reg_we && ctl_o.b_is_imm); // R10
    if (ctl_o.branch)
      AST_BRANCH_SUBTRACTS: assert (ctl_o.alu_op == ALU_SUB && !ctl_o.b_is_imm); // R6
    if (ctl_o.dst_is_rd)
      AST_RD_ONLY_REG_OPS: assert (ctl_o.reg_we && !ctl_o.b_is_imm); // R1
  end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       reg_we_o,
  output logic       dst_is_rd_o,
  output logic       b_is_imm_o,
  output logic       ext_signed_o,
  output logic [1:0] alu_op_o,
  output logic       mem_we_o,
  output logic       load_sel_o,
  output logic       branch_o
);

  logic    is_reg;
  opkind_e op_kind;
  opkind_e fn_kind;
  opkind_e sel_kind;
  ctl_t    ctl;

  ctl_op_classify i_classify (
    .op_i     (op_i),
    .is_reg_o (is_reg),
    .kind_o   (op_kind)
  );

  ctl_fn_decode i_fn_decode (
    .en_i   (is_reg),
    .fn_i   (fn_i),
    .kind_o (fn_kind)
  );

  always_comb begin
    sel_kind = is_reg ? fn_kind : op_kind;
  end

  ctl_point_gen i_point_gen (
    .kind_i (sel_kind),
    .ctl_o  (ctl)
  );

  always_comb begin
    reg_we_o     = ctl.reg_we;
    dst_is_rd_o  = ctl.dst_is_rd;
    b_is_imm_o   = ctl.b_is_imm;
    ext_signed_o = ctl.ext_signed;
    alu_op_o     = ctl.alu_op;
    mem_we_o     = ctl.mem_we;
    load_sel_o   = ctl.load_sel;
    branch_o     = ctl.branch;
  end

  always_comb begin
    if (mem_we_o)
      AST_STORE_OPCODE: assert (op_i == OPC_STORE); // R5
    if (op_i != OPC_REG && op_i != OPC_ORIMM && op_i != OPC_LOAD &&
        op_i != OPC_STORE && op_i != OPC_BREQ)
      AST_UNKNOWN_IDLE: assert (!reg_we_o && !mem_we_o && !branch_o); // R7
    if (op_i == OPC_REG && fn_i != FNC_ADD && fn_i != FNC_SUB)
      AST_BAD_FN_IDLE: assert (!reg_we_o && !mem_we_o && !branch_o); // R8
  end

endmodule

// File: tb/test_ctl_decoder.sv
module test_ctl_decoder;

  logic       clk;
  logic [5:0] op;
  logic [5:0] fn;
  logic       reg_we, dst_is_rd, b_is_imm, ext_signed, mem_we, load_sel, branch;
  logic [1:0] alu_op;

  int n_checks;
  int n_fail;
  bit done;

  ctl_decoder i_ctl_decoder (
    .op_i         (op),
    .fn_i         (fn),
    .reg_we_o     (reg_we),
    .dst_is_rd_o  (dst_is_rd),
    .b_is_imm_o   (b_is_imm),
    .ext_signed_o (ext_signed),
    .alu_op_o     (alu_op),
    .mem_we_o     (mem_we),
    .load_sel_o   (load_sel),
    .branch_o     (branch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Packed order: reg_we dst_is_rd b_is_imm ext_signed alu_op[1:0] mem_we load_sel branch
  localparam logic [8:0] EXP_ADD   = 9'b1_1_0_0_00_0_0_0;
  localparam logic [8:0] EXP_SUB   = 9'b1_1_0_0_01_0_0_0;
  localparam logic [8:0] EXP_ORI   = 9'b1_0_1_0_10_0_0_0;
  localparam logic [8:0] EXP_LOAD  = 9'b1_0_1_1_00_0_1_0;
  localparam logic [8:0] EXP_STORE = 9'b0_0_1_1_00_1_0_0;
  localparam logic [8:0] EXP_BEQ   = 9'b0_0_0_1_01_0_0_1;
  localparam logic [8:0] EXP_IDLE  = 9'b0;

  function automatic logic [8:0] observed();
    return {reg_we, dst_is_rd, b_is_imm, ext_signed, alu_op, mem_we, load_sel, branch};
  endfunction

  task automatic apply_and_check(input logic [5:0] o, input logic [5:0] f,
                                 input logic [8:0] exp, input string req);
    @(posedge clk);
    op = o;
    fn = f;
    @(negedge clk);
    n_checks++;
    if (observed() !== exp) begin
      n_fail++;
      $display("FAIL %s op=%02h fn=%02h actual=%09b expected=%09b",
               req, o, f, observed(), exp);
    end
  endtask

  task automatic t_reset_state();
    // All-zero instruction word: opcode 0 with function 0 is unassigned
    apply_and_check(6'h00, 6'h00, EXP_IDLE, "R8");
  endtask

  task automatic t_reg_ops();
    apply_and_check(6'h00, 6'h21, EXP_ADD, "R1");
    apply_and_check(6'h00, 6'h23, EXP_SUB, "R2");
    apply_and_check(6'h00, 6'h21, EXP_ADD, "R1");
  endtask

  task automatic t_imm_ops();
    apply_and_check(6'h0D, 6'h00, EXP_ORI,   "R3");
    apply_and_check(6'h23, 6'h00, EXP_LOAD,  "R4");
    apply_and_check(6'h2B, 6'h00, EXP_STORE, "R5");
    apply_and_check(6'h04, 6'h00, EXP_BEQ,   "R6");
  endtask

  task automatic t_unknown_ops();
    for (int k = 0; k < 64; k++) begin
      logic [5:0] o;
      o = k[5:0];
      if (o != 6'h00 && o != 6'h0D && o != 6'h23 && o != 6'h2B && o != 6'h04)
        apply_and_check(o, 6'h21, EXP_IDLE, "R7");
    end
  endtask

  task automatic t_reg_fn_sweep();
    for (int k = 0; k < 64; k++) begin
      logic [5:0] f;
      f = k[5:0];
      if (f == 6'h21)      apply_and_check(6'h00, f, EXP_ADD,  "R1");
      else if (f == 6'h23) apply_and_check(6'h00, f, EXP_SUB,  "R2");
      else                 apply_and_check(6'h00, f, EXP_IDLE, "R8");
    end
  endtask

  task automatic t_fn_ignored_r9();
    for (int k = 0; k < 64; k++) begin
      logic [5:0] f;
      f = k[5:0];
      apply_and_check(6'h0D, f, EXP_ORI,   "R9");
      apply_and_check(6'h23, f, EXP_LOAD,  "R9");
      apply_and_check(6'h2B, f, EXP_STORE, "R9");
      apply_and_check(6'h04, f, EXP_BEQ,   "R9");
    end
  endtask

  task automatic t_exclusive_r10();
    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      op = k[5:0];
      fn = 6'h21;
      @(negedge clk);
      n_checks++;
      if ((32'(reg_we) + 32'(mem_we) + 32'(branch)) > 1 ||
          (load_sel && !(reg_we && b_is_imm))) begin
        n_fail++;
        $display("FAIL R10 op=%02h actual=%09b expected=exclusive enables",
                 op, observed());
      end
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    op = 6'h00;
    fn = 6'h00;
    t_reset_state();
    t_reg_ops();
    t_imm_ops();
    t_unknown_ops();
    t_reg_fn_sweep();
    t_fn_ignored_r9();
    t_exclusive_r10();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule